// File: doc/BRIEF.md
# Memory Region Decoder with Read Aligner

This block sits between a CPU load/store port and a set of on-chip and cartridge memories. Address bits 27:24 pick a target memory, and the in-region offset wraps under a per-target mask, so every region repeats through its address window. The block drives one shared memory-side bus. That bus carries a one-hot target select, the wrapped byte offset, byte-lane write strobes and lane-replicated write data. Each target returns an aligned 32-bit word one cycle after it is selected.

Write permission depends on the target and on the access size. A request that is not permitted selects nothing and strobes nothing. Read data is formatted one cycle after the request. Halfwords and bytes are zero-extended and taken from the addressed lane. Misaligned word reads come back rotated, not faulted. Reads from the register file are built from two halfword registers, and the second index is given on its own port. A ROM read at or beyond the installed ROM size returns zero, as does any read from a target that does not allow that size.

Top module: `memdec_top`

## Requirements
- R1: The target follows address bits 27:24: 2 work RAM, 3 internal RAM, 4 register file, 5 palette, 6 video RAM, 7 sprite table, 8 through 13 ROM, 14 save RAM. The select bit index is work RAM 0, internal RAM 1, register file 2, palette 3, video RAM 4, sprite table 5, ROM 6, save RAM 7. For regions 0, 1 and 15, no select is raised and reads return zero. Address bits 31:28 are ignored.
- R2: `mem_off_o` equals address bits 24:0 ANDed with 2^AW-1, where AW is the parameter of the selected target. All six ROM regions use `ROM_AW`.
- R3: A word read returns the aligned word rotated right by 8 times address bits 1:0.
- R4: A halfword read returns the lane picked by address bit 1, and a byte read returns the lane picked by address bits 1:0. Both are zero-extended.
- R5: A ROM read whose wrapped byte offset is at least `rom_size_i` raises no select and returns zero.
- R6: A register-file read takes the low half from the halfword register at `mem_off_o` and the high half from the register at `io_hi_off_o`, which is the offset ORed with 2. Word reads are then rotated as in R3. A halfword read returns the low half. A byte read returns the byte picked by address bit 0.
- R7: A permitted write raises the strobes on `mem_be_o` as follows: all four for a word, lanes {1,0} or {3,2} by address bit 1 for a halfword, and lane addr[1:0] for a byte. For a halfword `mem_wdata_o` repeats wdata[15:0] twice, for a byte it repeats wdata[7:0] four times, and for a word it is wdata as is.
- R8: Byte writes to the register file, palette, video RAM and sprite table have no effect. Writes of any size to ROM have no effect.
- R9: A word write to video RAM happens only when address bits 23:0 are below `VRAM_SIZE`-2. A halfword write happens only when they are below `VRAM_SIZE`.
- R10: Byte reads of palette and video RAM return zero. All sprite-table reads return zero. Save RAM accepts only byte reads and byte writes.
- R11: Select, offset, strobes and write data respond in the request cycle. `rvalid_o` is high exactly in the cycle after a read request, with `rdata_o` valid in that cycle. Otherwise `rdata_o` is zero. Both are zero in reset.
- R12: Size code 3 performs no access: there is no select, no strobe, and the read returns zero. Size codes are 0 byte, 1 halfword, 2 word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 none |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Write data, right-justified |
| rom_size_i | input | ROM_AW+1 | Installed ROM size in bytes |
| mem_sel_o | output | 8 | One-hot target select |
| mem_off_o | output | 25 | Wrapped byte offset |
| io_hi_off_o | output | IO_AW | Register-file offset for the high half |
| mem_be_o | output | 4 | Byte-lane write strobes |
| mem_wdata_o | output | 32 | Lane-replicated write data |
| mem_rdata_i | input | 8x32 | Aligned word from each target, one cycle after select |
| rvalid_o | output | 1 | Read result valid |
| rdata_o | output | 32 | Formatted read data |

## Verification
The select, the offset, the second register index, the strobes and the replicated write data are combinational. The bench therefore checks them 1 ns after it drives a request at the falling edge, inside the same cycle. The modelled memories register their words on the next rising edge, and `rdata_o` and `rvalid_o` follow from registered request attributes. Read data and memory contents are therefore compared at the falling edge that follows that rising edge, with the request already removed. The sweep covers every region nibble, every size code and every low-address pair. It uses offsets that straddle the ROM size, the two video RAM write limits, and the wrap of each mask.

// File: rtl/memdec_pkg.sv
`timescale 1ns/1ps
package memdec_pkg;
  localparam int NT    = 8;
  localparam int OFF_W = 25;

  typedef enum logic [2:0] {
    T_WRAM, T_IRAM, T_IO, T_PAL, T_VRAM, T_OAM, T_ROM, T_SRAM
  } tgt_e;

  typedef enum logic [1:0] {SZ_B, SZ_H, SZ_W, SZ_X} size_e;

  typedef struct packed {
    logic hit;
    tgt_e tgt;
  } route_t;

  function automatic logic [OFF_W-1:0] aw_mask(input int aw);
    return OFF_W'((64'd1 << aw) - 64'd1);
  endfunction

  function automatic route_t route(input logic [3:0] r);
    route_t o;
    o.hit = 1'b1;
    o.tgt = T_WRAM;
    case (r)
      4'h2: o.tgt = T_WRAM;
      4'h3: o.tgt = T_IRAM;
      4'h4: o.tgt = T_IO;
      4'h5: o.tgt = T_PAL;
      4'h6: o.tgt = T_VRAM;
      4'h7: o.tgt = T_OAM;
      4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD: o.tgt = T_ROM;
      4'hE: o.tgt = T_SRAM;
      default: o.hit = 1'b0;
    endcase
    return o;
  endfunction

  function automatic logic rd_allow(input tgt_e t, input size_e s);
    if (s == SZ_X) return 1'b0;
    case (t)
      T_PAL, T_VRAM: return s != SZ_B;
      T_OAM:         return 1'b0;
      T_SRAM:        return s == SZ_B;
      default:       return 1'b1;
    endcase
  endfunction

  function automatic logic wr_allow(input tgt_e t, input size_e s);
    if (s == SZ_X) return 1'b0;
    case (t)
      T_WRAM, T_IRAM:         return 1'b1;
      T_IO, T_PAL, T_VRAM, T_OAM: return s != SZ_B;
      T_SRAM:                 return s == SZ_B;
      default:                return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/memdec_region.sv
`timescale 1ns/1ps
module memdec_region
  import memdec_pkg::*;
#(
  parameter logic [NT-1:0][OFF_W-1:0] MASKS = '0,
  parameter int VRAM_SIZE = 98304,
  parameter int RS_W      = 26
) (
  input  logic [27:0]      addr_i,
  input  logic [1:0]       size_i,
  input  logic [RS_W-1:0]  rom_size_i,
  output logic             hit_o,
  output tgt_e             tgt_o,
  output logic [OFF_W-1:0] off_o,
  output logic             rd_ok_o,
  output logic             wr_ok_o
);
  localparam int RAW_W = 24;
  localparam int CMP_W = (OFF_W > RS_W) ? OFF_W + 1 : RS_W + 1;

  route_t rt;
  size_e  sz;
  logic   rom_in, vram_ok;
  logic [RAW_W-1:0] raw;

  assign rt    = route(addr_i[27:24]);
  assign sz    = size_e'(size_i);
  assign hit_o = rt.hit;
  assign tgt_o = rt.tgt;
  assign off_o = addr_i[OFF_W-1:0] & MASKS[rt.tgt];
  assign raw   = addr_i[RAW_W-1:0];

  assign rom_in = CMP_W'(off_o) < CMP_W'(rom_size_i);

  // video RAM write limits use the unwrapped offset
  always_comb begin
    case (sz)
      SZ_W:    vram_ok = raw < RAW_W'(VRAM_SIZE - 2);
      SZ_H:    vram_ok = raw < RAW_W'(VRAM_SIZE);
      default: vram_ok = 1'b0;
    endcase
  end

  assign rd_ok_o = rt.hit && rd_allow(rt.tgt, sz) && (rt.tgt != T_ROM || rom_in);
  assign wr_ok_o = rt.hit && wr_allow(rt.tgt, sz) && (rt.tgt != T_VRAM || vram_ok);
endmodule

// File: rtl/memdec_lanes.sv
`timescale 1ns/1ps
module memdec_lanes
  import memdec_pkg::*;
(
  input  logic [1:0]  size_i,
  input  logic [1:0]  lo_i,
  input  logic [31:0] wdata_i,
  output logic [3:0]  be_o,
  output logic [31:0] wdata_o
);
  size_e sz;
  assign sz = size_e'(size_i);

  for (genvar j = 0; j < 4; j++) begin : g_lane
    always_comb begin
      case (sz)
        SZ_B: begin
          be_o[j]          = (lo_i == 2'(j));
          wdata_o[8*j +: 8] = wdata_i[7:0];
        end
        SZ_H: begin
          be_o[j]          = (lo_i[1] == 1'(j >> 1));
          wdata_o[8*j +: 8] = wdata_i[8*(j%2) +: 8];
        end
        SZ_W: begin
          be_o[j]          = 1'b1;
          wdata_o[8*j +: 8] = wdata_i[8*j +: 8];
        end
        default: begin
          be_o[j]          = 1'b0;
          wdata_o[8*j +: 8] = wdata_i[8*j +: 8];
        end
      endcase
    end
  end
endmodule

// File: rtl/memdec_align.sv
`timescale 1ns/1ps
module memdec_align
  import memdec_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_req_i,
  input  logic                live_i,
  input  tgt_e                tgt_i,
  input  logic [1:0]          size_i,
  input  logic [1:0]          lo_i,
  input  logic [NT-1:0][31:0] mem_rdata_i,
  output logic                rvalid_o,
  output logic [31:0]         rdata_o
);
  logic        v_q, live_q;
  tgt_e        tgt_q;
  size_e       size_q;
  logic [1:0]  lo_q;
  logic [31:0] w, fmt;
  logic [63:0] rot;
  logic        is_io;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q    <= 1'b0;
      live_q <= 1'b0;
      tgt_q  <= T_WRAM;
      size_q <= SZ_B;
      lo_q   <= '0;
    end else begin
      v_q    <= rd_req_i;
      live_q <= rd_req_i && live_i;
      if (rd_req_i) begin
        tgt_q  <= tgt_i;
        size_q <= size_e'(size_i);
        lo_q   <= lo_i;
      end
    end
  end

  assign w     = mem_rdata_i[tgt_q];
  assign is_io = (tgt_q == T_IO);
  assign rot   = {w, w} >> {lo_q, 3'b000};

  // register file lanes already point at the addressed halfword
  always_comb begin
    case (size_q)
      SZ_W:    fmt = rot[31:0];
      SZ_H:    fmt = {16'h0, (is_io || !lo_q[1]) ? w[15:0] : w[31:16]};
      SZ_B:    fmt = {24'h0, is_io ? (lo_q[0] ? w[15:8] : w[7:0]) : rot[7:0]};
      default: fmt = '0;
    endcase
  end

  assign rvalid_o = v_q;
  assign rdata_o  = (v_q && live_q) ? fmt : '0;

  p_rvalid_due_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> rvalid_o);
  p_rvalid_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> !rvalid_o && rdata_o == '0);
  p_dead_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && !live_i) |=> rdata_o == '0);
endmodule

// File: rtl/memdec_top.sv
`timescale 1ns/1ps
module memdec_top
  import memdec_pkg::*;
#(
  parameter int WRAM_AW   = 18,
  parameter int IRAM_AW   = 15,
  parameter int IO_AW     = 10,
  parameter int PAL_AW    = 10,
  parameter int VRAM_AW   = 17,
  parameter int VRAM_SIZE = 98304,
  parameter int OAM_AW    = 10,
  parameter int ROM_AW    = 25,
  parameter int SRAM_AW   = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [1:0]          size_i,
  input  logic [31:0]         addr_i,
  input  logic [31:0]         wdata_i,
  input  logic [ROM_AW:0]     rom_size_i,
  output logic [NT-1:0]       mem_sel_o,
  output logic [OFF_W-1:0]    mem_off_o,
  output logic [IO_AW-1:0]    io_hi_off_o,
  output logic [3:0]          mem_be_o,
  output logic [31:0]         mem_wdata_o,
  input  logic [NT-1:0][31:0] mem_rdata_i,
  output logic                rvalid_o,
  output logic [31:0]         rdata_o
);
  localparam logic [NT-1:0][OFF_W-1:0] MASKS = {
    aw_mask(SRAM_AW), aw_mask(ROM_AW), aw_mask(OAM_AW), aw_mask(VRAM_AW),
    aw_mask(PAL_AW),  aw_mask(IO_AW),  aw_mask(IRAM_AW), aw_mask(WRAM_AW)};
  localparam int RS_W = ROM_AW + 1;

  logic       hit, rd_ok, wr_ok, fire;
  tgt_e       tgt;
  logic [3:0] be;
  logic       unused_hi;

  assign unused_hi = ^addr_i[31:28];

  memdec_region #(.MASKS(MASKS), .VRAM_SIZE(VRAM_SIZE), .RS_W(RS_W)) u_region (
    .addr_i(addr_i[27:0]), .size_i(size_i), .rom_size_i(rom_size_i),
    .hit_o(hit), .tgt_o(tgt), .off_o(mem_off_o), .rd_ok_o(rd_ok), .wr_ok_o(wr_ok));

  memdec_lanes u_lanes (
    .size_i(size_i), .lo_i(addr_i[1:0]), .wdata_i(wdata_i),
    .be_o(be), .wdata_o(mem_wdata_o));

  memdec_align u_align (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_req_i(req_i && !we_i), .live_i(rd_ok),
    .tgt_i(tgt), .size_i(size_i), .lo_i(addr_i[1:0]), .mem_rdata_i(mem_rdata_i),
    .rvalid_o(rvalid_o), .rdata_o(rdata_o));

  assign fire        = req_i && hit && (we_i ? wr_ok : rd_ok);
  assign mem_be_o    = (req_i && we_i && wr_ok) ? be : 4'b0;
  assign io_hi_off_o = mem_off_o[IO_AW-1:0] | IO_AW'(2);

  for (genvar t = 0; t < NT; t++) begin : g_sel
    assign mem_sel_o[t] = fire && (tgt == tgt_e'(t));

    p_off_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_sel_o[t] |-> (mem_off_o & ~MASKS[t]) == '0);
  end

  p_sel_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mem_sel_o));
  p_be_with_sel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|mem_be_o) |-> (|mem_sel_o) && we_i);
  p_rom_no_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_sel_o[T_ROM] |-> !we_i);
  p_byte_periph_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && size_i == SZ_B) |->
      !(mem_sel_o[T_IO] || mem_sel_o[T_PAL] || mem_sel_o[T_VRAM] || mem_sel_o[T_OAM]));
  p_vram_word_lim_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_sel_o[T_VRAM] && we_i && size_i == SZ_W) |-> addr_i[23:0] < 24'(VRAM_SIZE - 2));
  p_sram_byte_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_sel_o[T_SRAM] |-> size_i == SZ_B);
  p_oam_no_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_sel_o[T_OAM] |-> we_i);
  p_no_size3_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i == SZ_X) |-> mem_sel_o == '0 && mem_be_o == '0);
endmodule

// File: tb/tb_memdec_top.sv
`timescale 1ns/1ps
module tb_memdec_top;
  import memdec_pkg::*;
  localparam int WA = 6, IA = 5, OA = 4, PA = 4, VA = 6, VS = 48, MA = 4, RA = 7, SA = 5;
  localparam int ROMSZ = 100;

  logic clk = 0, rst_n = 0, req = 0, we = 0;
  logic [1:0] sz = 0;
  logic [31:0] addr = 0, wd = 0;
  logic [RA:0] romsz = (RA+1)'(ROMSZ);
  logic [NT-1:0] sel;
  logic [OFF_W-1:0] off;
  logic [OA-1:0] hioff;
  logic [3:0] be;
  logic [31:0] wdo, rdata;
  logic [NT-1:0][31:0] rq;
  logic rvalid;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] mb [NT][128];

  always #10 clk = ~clk;

  memdec_top #(.WRAM_AW(WA), .IRAM_AW(IA), .IO_AW(OA), .PAL_AW(PA), .VRAM_AW(VA),
    .VRAM_SIZE(VS), .OAM_AW(MA), .ROM_AW(RA), .SRAM_AW(SA)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size_i(sz), .addr_i(addr),
    .wdata_i(wd), .rom_size_i(romsz), .mem_sel_o(sel), .mem_off_o(off),
    .io_hi_off_o(hioff), .mem_be_o(be), .mem_wdata_o(wdo), .mem_rdata_i(rq),
    .rvalid_o(rvalid), .rdata_o(rdata));

  function automatic logic [15:0] ioreg(int o);
    return {mb[2][(o | 1) & 127], mb[2][(o & ~1) & 127]};
  endfunction

  function automatic logic [31:0] bword(int t, int o);
    int b = (o & ~3) & 127;
    return {mb[t][b+3], mb[t][b+2], mb[t][b+1], mb[t][b]};
  endfunction

  // memory models: synchronous word read, byte-lane write
  always @(posedge clk) begin
    int b;
    for (int t = 0; t < NT; t++) if (sel[t]) begin
      b = (int'(off) & ~3) & 127;
      for (int j = 0; j < 4; j++) if (be[j]) mb[t][b+j] <= wdo[8*j +: 8];
      rq[t] <= (t == 2) ? {ioreg(int'(hioff)), ioreg(int'(off))} : bword(t, int'(off));
    end
  end

  function automatic int tmap(int r);
    case (r)
      2: return 0; 3: return 1; 4: return 2; 5: return 3; 6: return 4; 7: return 5;
      8, 9, 10, 11, 12, 13: return 6; 14: return 7;
      default: return -1;
    endcase
  endfunction

  function automatic int awof(int t);
    case (t)
      0: return WA; 1: return IA; 2: return OA; 3: return PA;
      4: return VA; 5: return MA; 6: return RA; default: return SA;
    endcase
  endfunction

  function automatic bit rd_perm(int t, int s, int o);
    if (t < 0 || s == 3) return 0;
    case (t)
      3, 4: return s != 0;
      5: return 0;
      6: return o < ROMSZ;
      7: return s == 0;
      default: return 1;
    endcase
  endfunction

  function automatic bit wr_perm(int t, int s, int raw);
    if (t < 0 || s == 3) return 0;
    case (t)
      0, 1: return 1;
      2, 3, 5: return s != 0;
      4: return (s == 2) ? raw < VS - 2 : (s == 1) ? raw < VS : 0;
      6: return 0;
      default: return s == 0;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h addr=%h size=%0d we=%0b", tag, act, exp, addr, sz, we);
    end
  endtask

  task automatic do_read(logic [31:0] a, int s);
    int t, o, lo;
    bit p;
    logic [31:0] w, e;
    logic [15:0] h;
    string tag;
    @(negedge clk);
    addr = a; sz = 2'(s); we = 0; req = 1;
    #1;
    t  = tmap(int'(a[27:24]));
    o  = (t < 0) ? 0 : int'(a[24:0]) & ((1 << awof(t)) - 1);
    lo = int'(a[1:0]);
    p  = rd_perm(t, s, o);
    chk(sel == (p ? NT'(1 << t) : '0), "R1", 32'(sel), p ? 32'(1 << t) : 0);
    if (p) chk(int'(off) == o, "R2", 32'(off), 32'(o));
    if (p && t == 2) chk(int'(hioff) == ((o | 2) & 15), "R6", 32'(hioff), 32'((o | 2) & 15));
    e = '0;
    if (p) begin
      w = (t == 2) ? {ioreg(o | 2), ioreg(o)} : bword(t, o);
      h = ioreg(o);
      case (s)
        2: e = (w >> (8*lo)) | (w << (32 - 8*lo));
        1: e = (t == 2) ? {16'h0, h} : {16'h0, lo[1] ? w[31:16] : w[15:0]};
        default: e = (t == 2) ? {24'h0, o[0] ? h[15:8] : h[7:0]} : (w >> (8*lo)) & 32'hFF;
      endcase
    end
    if (t < 0) tag = "R1";
    else if (s == 3) tag = "R12";
    else if (t == 6 && !p) tag = "R5";
    else if (!p) tag = "R10";
    else if (t == 2) tag = "R6";
    else if (s == 2 && lo != 0) tag = "R3";
    else tag = "R4";
    @(posedge clk);
    @(negedge clk);
    req = 0;
    chk(rvalid == 1'b1, "R11", 32'(rvalid), 1);
    chk(rdata == e, tag, rdata, e);
  endtask

  task automatic do_write(logic [31:0] a, int s, logic [31:0] d);
    int t, o, lo, b;
    bit p;
    logic [3:0] eb;
    logic [31:0] ew;
    logic [7:0] old [4];
    string tag;
    @(negedge clk);
    addr = a; sz = 2'(s); we = 1; req = 1; wd = d;
    #1;
    t  = tmap(int'(a[27:24]));
    o  = (t < 0) ? 0 : int'(a[24:0]) & ((1 << awof(t)) - 1);
    lo = int'(a[1:0]);
    p  = wr_perm(t, s, int'(a[23:0]));
    eb = (s == 2) ? 4'hF : (s == 1) ? (lo[1] ? 4'hC : 4'h3) : (s == 0) ? 4'(1 << lo) : 4'h0;
    ew = (s == 1) ? {2{d[15:0]}} : (s == 0) ? {4{d[7:0]}} : d;
    if (t < 0) tag = "R1";
    else if (s == 3) tag = "R12";
    else if (t == 6) tag = "R8";
    else if (t == 4 && s != 0) tag = "R9";
    else if (s == 0 && t >= 2 && t <= 5) tag = "R8";
    else if (t == 7) tag = "R10";
    else tag = "R7";
    chk(sel == (p ? NT'(1 << t) : '0), tag, 32'(sel), p ? 32'(1 << t) : 0);
    chk(be == (p ? eb : 4'h0), tag, 32'(be), p ? 32'(eb) : 0);
    if (s != 3) chk(wdo == ew, "R7", wdo, ew);
    b = (o & ~3) & 127;
    if (t >= 0) for (int j = 0; j < 4; j++) old[j] = mb[t][b+j];
    @(posedge clk);
    @(negedge clk);
    req = 0; we = 0;
    chk(rvalid == 1'b0, "R11", 32'(rvalid), 0);
    if (t >= 0) for (int j = 0; j < 4; j++)
      chk(mb[t][b+j] == ((p && eb[j]) ? ew[8*j +: 8] : old[j]), tag,
          32'(mb[t][b+j]), 32'((p && eb[j]) ? ew[8*j +: 8] : old[j]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R11 watchdog expired act=0 exp=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int bases [6] = '{32'h10, 32'h2C, 32'h30, 32'h60, 32'h64, 32'h2C4};
    for (int t = 0; t < NT; t++) for (int i = 0; i < 128; i++) mb[t][i] = 8'(t*37 + i*11 + 3);
    rq = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rvalid == 0 && rdata == 0, "R11", rdata, 0);
    chk(sel == 0 && be == 0, "R11", 32'({sel, be}), 0);
    rst_n = 1;
    for (int r = 0; r < 16; r++)
      for (int bi = 0; bi < 6; bi++)
        for (int s = 0; s < 4; s++)
          for (int lo = 0; lo < 4; lo++) begin
            logic [31:0] a;
            a = {4'(r ^ 9), 4'(r), 24'(bases[bi] + lo)};
            do_read(a, s);
            do_write(a, s, {a[7:0] ^ 8'h5A, 8'(s*17 + lo), 8'(r*13 + bi), 8'hC3});
            do_read(a, s);
          end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule